// File: doc/BRIEF.md
# Bit-Banged Serial Clock-Chip Port

This block is a CPU-side I/O port that lets software run a three-wire serial real-time-clock device entirely by bit-banging. Every CPU write to the port loads one byte into an output register. Four bits of that byte drive the clock device: its transfer-enable line, its serial clock, its serial data, and a direction bit that chooses whether the port drives the shared data pin or leaves it to the device. A CPU read of the port returns the level on the data pin in bit 7.

The clock device has no chip-select. Software frames a transfer by raising the transfer-enable line. It then shifts a command byte out one bit per clock pulse, with the least significant bit first. For a write command, the data bytes follow in the same way. For a read command, software clears the direction bit and reads the port once per clock pulse to collect each returned bit. Each serial edge therefore costs one port write.

Top module: `rtc_bitbang_port`

## Requirements
- R1: A port write is recognised only while `port_sel_n` and `wr_n` are both low. A port read is recognised only while `port_sel_n` and `rd_n` are both low.
- R2: On a clock edge where a port write is recognised, the register loads `wdata`. Its new value appears on the outputs right after that edge.
- R3: Register bit 4 drives `rtc_rst`, bit 6 drives `rtc_sclk` and bit 7 drives `dq_out`.
- R4: Register bit 5 is the direction bit. When it is 1, `dq_oe` is 1 and the port drives the data pin. When it is 0, `dq_oe` is 0 and the pin is released to the device.
- R5: During a recognised read with the direction bit at 0, `rdata[7]` equals `dq_in`, with no clock delay. With the direction bit at 1, `rdata[7]` is 0.
- R6: `rdata[6:0]` is always 0, and all of `rdata` is 0 when no read is recognised.
- R7: An active-low `rst_n` clears the register at once. This leaves `rtc_rst`, `rtc_sclk`, `dq_out` and `dq_oe` all low.
- R8: Write cycles without the port select, or select cycles without the write strobe, leave every output unchanged.
- R9: A read transfer works end to end: a least-significant-bit-first command byte with bit 0 set, followed by eight sampled bits with the direction bit at 0, returns the byte the device sends.
- R10: A write transfer works end to end: a command byte with bit 0 clear, followed by eight data bits, delivers that data byte to the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel_n | input | 1 | Active-low select decoded for this port |
| rd_n | input | 1 | Active-low CPU read strobe |
| wr_n | input | 1 | Active-low CPU write strobe |
| wdata | input | 8 | CPU data bus into the port |
| dq_in | input | 1 | Level observed on the shared serial data pin |
| rtc_rst | output | 1 | Transfer-enable line to the clock device |
| rtc_sclk | output | 1 | Serial clock to the clock device |
| dq_out | output | 1 | Value driven onto the serial data pin |
| dq_oe | output | 1 | Drive enable for the serial data pin |
| rdata | output | 8 | Read-back byte to the CPU |

## Verification
All pin outputs move one clock edge after a recognised write. The bench therefore raises the write strobe at a falling edge and checks the pins at the next falling edge, once the loading edge has passed. Read data is combinational, so the bench samples it 1 ns into an active read strobe, inside the same cycle. Reset clears the pins without waiting for a clock, so they are checked while reset is still held. The serial device model acts on the edges of `rtc_sclk` and `rtc_rst`. Each bit it returns is therefore settled on the pin before the next port read.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int BUS_W   = 8;
  localparam int RST_POS = 4;
  localparam int DIR_POS = 5;
  localparam int CLK_POS = 6;
  localparam int DAT_POS = 7;
  localparam int RD_POS  = 7;

  typedef struct packed {
    logic dout;
    logic sclk;
    logic dir;
    logic en;
  } pin_ctl_t;

  function automatic pin_ctl_t decode_ctl(input logic [BUS_W-1:0] b);
    pin_ctl_t c;
    c.en   = b[RST_POS];
    c.dir  = b[DIR_POS];
    c.sclk = b[CLK_POS];
    c.dout = b[DAT_POS];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] read_word(input logic act, input logic dir,
                                                 input logic dq);
    logic [BUS_W-1:0] w;
    w = '0;
    w[RD_POS] = act & ~dir & dq;
    return w;
  endfunction
endpackage

// File: rtl/rtc_port_decode.sv
module rtc_port_decode (
  input  logic port_sel_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_act,
  output logic rd_act
);
  logic wr_strobe_n;
  logic rd_strobe_n;

  assign wr_strobe_n = port_sel_n | wr_n;
  assign rd_strobe_n = port_sel_n | rd_n;
  assign wr_act      = ~wr_strobe_n;
  assign rd_act      = ~rd_strobe_n;
endmodule

// File: rtl/rtc_port_latch.sv
module rtc_port_latch #(
  parameter int W = rtc_port_pkg::BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_act,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else if (wr_act) lat <= wdata;
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && wr_act) |=> (lat == $past(wdata)));

  // R8
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !wr_act) |=> (lat == $past(lat)));
endmodule

// File: rtl/rtc_port_readmux.sv
module rtc_port_readmux #(
  parameter int W = rtc_port_pkg::BUS_W
) (
  input  logic         rd_act,
  input  logic         dir,
  input  logic         dq_in,
  output logic [W-1:0] rdata
);
  always_comb rdata = rtc_port_pkg::read_word(rd_act, dir, dq_in);
endmodule

// File: rtl/rtc_bitbang_port.sv
module rtc_bitbang_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_sel_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] wdata,
  input  logic       dq_in,
  output logic       rtc_rst,
  output logic       rtc_sclk,
  output logic       dq_out,
  output logic       dq_oe,
  output logic [7:0] rdata
);
  import rtc_port_pkg::*;

  logic             wr_act;
  logic             rd_act;
  logic [BUS_W-1:0] lat;
  pin_ctl_t         ctl;
  logic             lat_unused;

  rtc_port_decode i_decode (
    .port_sel_n (port_sel_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .wr_act     (wr_act),
    .rd_act     (rd_act)
  );

  rtc_port_latch #(.W(BUS_W)) i_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_act (wr_act),
    .wdata  (wdata),
    .lat    (lat)
  );

  assign ctl        = decode_ctl(lat);
  assign lat_unused = ^lat[3:0];

  assign rtc_rst  = ctl.en;
  assign rtc_sclk = ctl.sclk;
  assign dq_out   = ctl.dout;
  assign dq_oe    = ctl.dir;

  rtc_port_readmux #(.W(BUS_W)) i_readmux (
    .rd_act (rd_act),
    .dir    (ctl.dir),
    .dq_in  (dq_in),
    .rdata  (rdata)
  );

  // R3
  sclk_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_sclk != $past(rtc_sclk)) |-> $past(wr_act));

  // R5
  driven_pin_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && dq_oe) |-> (rdata == 8'h00));

  // R6
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_act) |-> (rdata == 8'h00));

  // R7
  reset_exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rtc_rst && !rtc_sclk && !dq_oe && !dq_out));
endmodule

// File: tb/test_rtc_bitbang_port.sv
module test_rtc_bitbang_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_sel_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic       dq_in;
  logic       rtc_rst, rtc_sclk, dq_out, dq_oe;
  logic [7:0] rdata;
  logic       tb_dq = 1'b0;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  localparam logic [7:0] DEV_BYTE = 8'hC6;

  always #2.5 clk = ~clk;

  rtc_bitbang_port i_rtc_bitbang_port (
    .clk(clk), .rst_n(rst_n), .port_sel_n(port_sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .dq_in(dq_in), .rtc_rst(rtc_rst), .rtc_sclk(rtc_sclk),
    .dq_out(dq_out), .dq_oe(dq_oe), .rdata(rdata)
  );

  // behavioural serial device
  logic [4:0] s_cnt = 5'd0;
  logic [7:0] s_cmd = 8'h00;
  logic [7:0] s_wr  = 8'h00;
  logic [4:0] s_idx;
  logic       s_drv;
  assign s_idx = s_cnt - 5'd8;
  assign s_drv = (s_cnt >= 5'd8 && s_cmd[0]) ? DEV_BYTE[s_idx[2:0]] : 1'b1;
  assign dq_in = dq_oe ? dq_out : (rtc_rst ? s_drv : tb_dq);

  always @(posedge rtc_sclk or negedge rtc_rst) begin
    if (!rtc_rst) s_cnt <= 5'd0;
    else begin
      if (s_cnt < 5'd8) s_cmd[s_cnt[2:0]] <= dq_in;
      else if (!s_cmd[0] && s_cnt < 5'd16) s_wr[s_idx[2:0]] <= dq_in;
      s_cnt <= s_cnt + 5'd1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic port_wr(input logic [7:0] v);
    @(negedge clk); port_sel_n = 1'b0; wr_n = 1'b0; wdata = v;
    @(negedge clk); port_sel_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic port_rd(output logic [7:0] r);
    @(negedge clk); port_sel_n = 1'b0; rd_n = 1'b0;
    #1 r = rdata;
    @(negedge clk); port_sel_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [7:0] pins_of(input logic en, input logic sc,
                                          input logic dr, input logic d);
    return {d, sc, dr, en, 4'b0000};
  endfunction

  function automatic logic [7:0] pins_now();
    return {4'b0000, dq_out, rtc_sclk, dq_oe, rtc_rst};
  endfunction

  task automatic shift_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      port_wr(pins_of(1'b1, 1'b0, 1'b1, b[i]));
      port_wr(pins_of(1'b1, 1'b1, 1'b1, b[i]));
    end
    port_wr(pins_of(1'b1, 1'b0, 1'b1, b[7]));
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    chk("R7 reset pins", pins_now(), 8'h00);
    chk("R6 reset rdata", rdata, 8'h00);
    rst_n = 1'b1;

    // R2 R3 R4: sweep every byte value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      port_wr(b);
      chk("R3 rtc_rst", {7'b0, rtc_rst}, {7'b0, b[4]});
      chk("R3 rtc_sclk", {7'b0, rtc_sclk}, {7'b0, b[6]});
      chk("R3 dq_out", {7'b0, dq_out}, {7'b0, b[7]});
      chk("R4 dq_oe", {7'b0, dq_oe}, {7'b0, b[5]});
      chk("R2 load", pins_now(), {4'b0, b[7], b[6], b[5], b[4]});
    end

    // R5 R6: read path for each direction and pin level
    for (int dr = 0; dr < 2; dr++) begin
      for (int d = 0; d < 2; d++) begin
        port_wr(pins_of(1'b0, 1'b0, dr[0], 1'b0));
        tb_dq = d[0];
        port_rd(r);
        chk("R5 read bit7", r, {(dr == 0) ? d[0] : 1'b0, 7'b0});
        #1 chk("R6 idle rdata", rdata, 8'h00);
      end
    end

    // R1 R8: partial strobes ignored
    port_wr(8'h70);
    @(negedge clk); port_sel_n = 1'b1; wr_n = 1'b0; wdata = 8'h80;
    repeat (2) @(negedge clk);
    chk("R8 no select", pins_now(), 8'h07);
    port_sel_n = 1'b0; wr_n = 1'b1; wdata = 8'h00;
    repeat (2) @(negedge clk);
    chk("R8 no write strobe", pins_now(), 8'h07);
    port_sel_n = 1'b1;
    port_wr(8'h00);
    tb_dq = 1'b1;
    @(negedge clk); port_sel_n = 1'b1; rd_n = 1'b0;
    #1 chk("R1 read needs select", rdata, 8'h00);
    @(negedge clk); port_sel_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    #1 chk("R1 read needs rd_n", rdata, 8'h00);
    @(negedge clk); port_sel_n = 1'b1;

    // R7: asynchronous reset mid-run
    port_wr(8'hF0);
    #1 rst_n = 1'b0;
    #1 chk("R7 async clear", pins_now(), 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R9: read transfer
    port_wr(pins_of(1'b1, 1'b0, 1'b1, 1'b0));
    shift_byte(8'h81);
    chk("R9 command seen", s_cmd, 8'h81);
    port_wr(pins_of(1'b1, 1'b0, 1'b0, 1'b0));
    got = 8'h00;
    for (int j = 0; j < 8; j++) begin
      port_rd(r);
      got[j] = r[7];
      port_wr(pins_of(1'b1, 1'b1, 1'b0, 1'b0));
      port_wr(pins_of(1'b1, 1'b0, 1'b0, 1'b0));
    end
    chk("R9 read byte", got, DEV_BYTE);
    port_wr(pins_of(1'b0, 1'b0, 1'b1, 1'b0));

    // R10: write transfer
    port_wr(pins_of(1'b1, 1'b0, 1'b1, 1'b0));
    shift_byte(8'h80);
    shift_byte(8'h5A);
    chk("R10 command seen", s_cmd, 8'h80);
    chk("R10 data delivered", s_wr, 8'h5A);
    port_wr(pins_of(1'b0, 1'b0, 1'b1, 1'b0));
    chk("R3 transfer closed", {7'b0, rtc_rst}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule